// File: doc/BRIEF.md
# Indexer Board Bus Slave with Interrupt Acknowledge

This block is the slave side of a simple parallel peripheral bus for a board that carries several stepper indexer channels. The bus carries an address, an active-low data bus, a read strobe and a write strobe. The block compares the upper address bits with a board block. The block sits at one of four locations, and two jumper inputs pick which one. Within that block the block serves two locations. One is a status word made of the per-channel running flags. The other is a small interrupt configuration register. The block answers every access aimed at the board with an acknowledge strobe.

The channels share one active-low service-request line per channel. When at least one channel asks for service and interrupts are enabled, the block raises the interrupt request. The host then reads an acknowledge address in a small global window. The configuration register picks one of the four addresses in that window, and the same field picks one data lane. During an acknowledge read the block drives only that one lane, and the lane carries its request level. The block holds its own request low while any acknowledge read is on the bus, whichever board that read addresses.

The bus has no stream traffic and no back-pressure. Each strobe is answered in the same cycle through combinational decode. The only state is the configuration register, which captures a write on the rising clock edge while the write strobe is high.

Top module: `idx_sbus_slave`

## Requirements
- R1: `board_sel_o` is high exactly when address bits [11:6] equal {4'b1010, jumper_i}, so the board block starts at 0xA00 + 0x40·jumper_i.
- R2: A read of board offset 0 drives all lanes. Lane N-1 carries the running flag of channel N, lanes at or above the channel count carry 0, and the bus value is the inverse of the internal value (`dbus_n_o = ~data`).
- R3: The configuration register resets to 0. A write to board offset 1 captures the inverted bus word masked to bit 5 (enable) and bits 4:3 (lane select). A read of offset 1 returns that masked word.
- R4: Outside acknowledge reads, `irq_o` is 1 exactly when the enable bit is set and at least one `svc_n_i` bit is 0.
- R5: `irq_o` is 0 while `rd_i` is high with the address in 0x040..0x043.
- R6: With the enable bit set, a read of address 0x040 + select is acknowledged. On that read exactly one lane is enabled, lane number = select, and that lane carries the enabled request level (1 if any channel requests).
- R7: Any other read inside the board block enables all lanes. Offsets other than 0 and 1 read 0.
- R8: `ack_o` is high for every read or write with `board_sel_o` high.
- R9: Accesses outside the board block are not acknowledged and enable no lane. This includes acknowledge reads at another lane's address or while the enable bit is 0.
- R10: Writes to any board offset other than 1 leave the configuration register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration register |
| rst_n | input | 1 | Asynchronous active-low reset |
| jumper_i | input | 2 | Board block select jumpers |
| addr_i | input | ADDR_W (12) | Bus address |
| rd_i | input | 1 | Read strobe, active high |
| wr_i | input | 1 | Write strobe, active high |
| dbus_n_i | input | DATA_W (8) | Active-low data from the bus |
| dbus_n_o | output | DATA_W (8) | Active-low data to the bus |
| dbus_oe_o | output | DATA_W (8) | Per-lane drive enable |
| ack_o | output | 1 | Access acknowledge |
| board_sel_o | output | 1 | Address is inside this board's block |
| running_i | input | N_CH (6) | Per-channel running flags |
| svc_n_i | input | N_CH (6) | Per-channel active-low service requests |
| irq_o | output | 1 | Interrupt request |

## Verification
The bench builds the block with its defaults: a 12-bit address, an 8-bit data bus, six channels and a page tag of 0xA. With six channels on eight lanes, the two top lanes of the status word must read 0. With a 12-bit address, all four jumper blocks and all four acknowledge addresses can be reached. The bench also checks that one block is not decoded when the jumpers select another. It drives acknowledge reads with requests pending and with none, at the board's own lane and at a foreign lane, and with interrupts disabled.

// File: rtl/idx_sbus_pkg.sv
package idx_sbus_pkg;
  localparam int CFG_EN_BIT  = 5;
  localparam int CFG_SEL_LSB = 3;
  localparam int ACK_BASE    = 'h040;
  localparam int OFF_STATUS  = 0;
  localparam int OFF_CFG     = 1;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_STATUS,
    RK_CFG,
    RK_OTHER,
    RK_ACK
  } rd_kind_e;
endpackage

// File: rtl/idx_sbus_decode.sv
module idx_sbus_decode
  import idx_sbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BLK_W  = 6,
  parameter int PAGE   = 10
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [1:0]        jumper_i,
  input  logic [1:0]        lane_sel_i,
  output logic              board_sel_o,
  output logic [BLK_W-1:0]  offset_o,
  output logic              any_ack_o,
  output logic              own_ack_o
);
  localparam int TAG_W  = ADDR_W - BLK_W;
  localparam int PAGE_W = TAG_W - 2;
  localparam logic [ADDR_W-3:0] ACK_GROUP = (ADDR_W-2)'(ACK_BASE >> 2);

  logic [TAG_W-1:0] tag_want;

  assign tag_want    = {PAGE_W'(PAGE), jumper_i};
  assign board_sel_o = (addr_i[ADDR_W-1:BLK_W] == tag_want);
  assign offset_o    = addr_i[BLK_W-1:0];
  assign any_ack_o   = (addr_i[ADDR_W-1:2] == ACK_GROUP);
  assign own_ack_o   = any_ack_o && (addr_i[1:0] == lane_sel_i);
endmodule

// File: rtl/idx_sbus_icfg.sv
module idx_sbus_icfg
  import idx_sbus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] cfg_o
);
  localparam logic [DATA_W-1:0] KEEP_MASK =
    (DATA_W'(1) << CFG_EN_BIT) | (DATA_W'(3) << CFG_SEL_LSB);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_o <= '0;
    else if (we_i) cfg_o <= wdata_i & KEEP_MASK;
  end
endmodule

// File: rtl/idx_sbus_steer.sv
module idx_sbus_steer
  import idx_sbus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int N_CH   = 6,
  parameter int BLK_W  = 6
) (
  input  logic              rd_i,
  input  logic              board_sel_i,
  input  logic [BLK_W-1:0]  offset_i,
  input  logic              ack_hit_i,
  input  logic              req_i,
  input  logic [1:0]        lane_sel_i,
  input  logic [N_CH-1:0]   running_i,
  input  logic [DATA_W-1:0] cfg_i,
  output logic [DATA_W-1:0] oe_o,
  output logic [DATA_W-1:0] data_o
);
  rd_kind_e          kind;
  logic [DATA_W-1:0] lane_hot;

  always_comb begin
    kind = RK_NONE;
    if (rd_i && ack_hit_i)
      kind = RK_ACK;
    else if (rd_i && board_sel_i) begin
      if (offset_i == BLK_W'(OFF_STATUS))   kind = RK_STATUS;
      else if (offset_i == BLK_W'(OFF_CFG)) kind = RK_CFG;
      else                                  kind = RK_OTHER;
    end
  end

  assign lane_hot = DATA_W'(1) << lane_sel_i;

  for (genvar b = 0; b < DATA_W; b++) begin : g_lane
    logic status_bit;
    if (b < N_CH) begin : g_ch
      assign status_bit = running_i[b];
    end else begin : g_pad
      assign status_bit = 1'b0;
    end

    assign oe_o[b] = (kind == RK_ACK) ? lane_hot[b] : (kind != RK_NONE);

    always_comb begin
      case (kind)
        RK_ACK:    data_o[b] = req_i;
        RK_STATUS: data_o[b] = status_bit;
        RK_CFG:    data_o[b] = cfg_i[b];
        default:   data_o[b] = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/idx_sbus_slave.sv
module idx_sbus_slave
  import idx_sbus_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int N_CH   = 6,
  parameter int BLK_W  = 6,
  parameter int PAGE   = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        jumper_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              rd_i,
  input  logic              wr_i,
  input  logic [DATA_W-1:0] dbus_n_i,
  output logic [DATA_W-1:0] dbus_n_o,
  output logic [DATA_W-1:0] dbus_oe_o,
  output logic              ack_o,
  output logic              board_sel_o,
  input  logic [N_CH-1:0]   running_i,
  input  logic [N_CH-1:0]   svc_n_i,
  output logic              irq_o
);
  logic              board_sel;
  logic [BLK_W-1:0]  offset;
  logic              any_ack, own_ack;
  logic [DATA_W-1:0] cfg_q, rd_data;
  logic              cfg_en;
  logic [1:0]        cfg_sel;
  logic              cfg_we;
  logic              req_raw;
  logic              ack_hit;

  idx_sbus_decode #(.ADDR_W(ADDR_W), .BLK_W(BLK_W), .PAGE(PAGE)) u_dec (
    .addr_i     (addr_i),
    .jumper_i   (jumper_i),
    .lane_sel_i (cfg_sel),
    .board_sel_o(board_sel),
    .offset_o   (offset),
    .any_ack_o  (any_ack),
    .own_ack_o  (own_ack)
  );

  assign cfg_we = wr_i && board_sel && (offset == BLK_W'(OFF_CFG));

  idx_sbus_icfg #(.DATA_W(DATA_W)) u_cfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .we_i   (cfg_we),
    .wdata_i(~dbus_n_i),
    .cfg_o  (cfg_q)
  );

  assign cfg_en  = cfg_q[CFG_EN_BIT];
  assign cfg_sel = cfg_q[CFG_SEL_LSB +: 2];
  assign req_raw = cfg_en && !(&svc_n_i);
  assign ack_hit = own_ack && cfg_en;

  idx_sbus_steer #(.DATA_W(DATA_W), .N_CH(N_CH), .BLK_W(BLK_W)) u_steer (
    .rd_i       (rd_i),
    .board_sel_i(board_sel),
    .offset_i   (offset),
    .ack_hit_i  (ack_hit),
    .req_i      (req_raw),
    .lane_sel_i (cfg_sel),
    .running_i  (running_i),
    .cfg_i      (cfg_q),
    .oe_o       (dbus_oe_o),
    .data_o     (rd_data)
  );

  assign dbus_n_o    = ~rd_data;
  assign board_sel_o = board_sel;
  assign irq_o       = req_raw && !(rd_i && any_ack);
  assign ack_o       = (board_sel && (rd_i || wr_i)) || (rd_i && ack_hit);
endmodule

// File: rtl/idx_sbus_slave_chk.sv
module idx_sbus_slave_chk #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8,
  parameter int BLK_W  = 6,
  parameter int PAGE   = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        jumper_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              rd_i,
  input logic              wr_i,
  input logic [DATA_W-1:0] dbus_oe_o,
  input logic              ack_o,
  input logic              irq_o,
  input logic              cfg_en,
  input logic [1:0]        cfg_sel
);
  localparam int PAGE_W = ADDR_W - BLK_W - 2;

  logic in_block, in_window, own_lane, cfg_write;
  assign in_block  = (addr_i[ADDR_W-1:BLK_W] == {PAGE_W'(PAGE), jumper_i});
  assign in_window = (addr_i[ADDR_W-1:2] == (ADDR_W-2)'('h10));
  assign own_lane  = in_window && (addr_i[1:0] == cfg_sel) && cfg_en;
  assign cfg_write = wr_i && in_block && (addr_i[BLK_W-1:0] == BLK_W'(1));

  assert_disabled_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_en |-> !irq_o);
  assert_window_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && in_window) |-> !irq_o);
  assert_single_lane_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && own_lane) |-> (ack_o && $onehot0(dbus_oe_o) && $countones(dbus_oe_o) == 1
                            && dbus_oe_o[cfg_sel]));
  assert_all_lanes_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_i && in_block) |-> (&dbus_oe_o));
  assert_board_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_block && (rd_i || wr_i)) |-> ack_o);
  assert_no_stray_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!(in_block && (rd_i || wr_i)) && !(rd_i && own_lane)) |-> (!ack_o && dbus_oe_o == '0));
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_write |=> ($stable(cfg_en) && $stable(cfg_sel)));
endmodule

bind idx_sbus_slave idx_sbus_slave_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLK_W(BLK_W), .PAGE(PAGE)
) chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .jumper_i (jumper_i),
  .addr_i   (addr_i),
  .rd_i     (rd_i),
  .wr_i     (wr_i),
  .dbus_oe_o(dbus_oe_o),
  .ack_o    (ack_o),
  .irq_o    (irq_o),
  .cfg_en   (cfg_en),
  .cfg_sel  (cfg_sel)
);

// File: tb/idx_sbus_slave_tb_top.sv
`timescale 1ns/1ps
module idx_sbus_slave_tb_top;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 8;
  localparam int N_CH   = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0]        jumper = '0;
  logic [ADDR_W-1:0] addr = '0;
  logic              rd = 1'b0, wr = 1'b0;
  logic [DATA_W-1:0] dbus_n_in = '1;
  logic [DATA_W-1:0] dbus_n_out, oe;
  logic              ack, bsel, irq;
  logic [N_CH-1:0]   running = '0;
  logic [N_CH-1:0]   svc_n = '1;

  always #2 clk = ~clk;

  idx_sbus_slave dut_i (
    .clk(clk), .rst_n(rst_n), .jumper_i(jumper), .addr_i(addr),
    .rd_i(rd), .wr_i(wr), .dbus_n_i(dbus_n_in), .dbus_n_o(dbus_n_out),
    .dbus_oe_o(oe), .ack_o(ack), .board_sel_o(bsel),
    .running_i(running), .svc_n_i(svc_n), .irq_o(irq)
  );

  typedef struct {
    logic [7:0] oe;
    logic [7:0] data;
    logic       ack;
    logic       irq;
    logic       bsel;
    string      tag;
  } exp_t;

  exp_t exp_q[$];
  int n_checks = 0;
  int n_fail = 0;
  bit done = 1'b0;

  function automatic exp_t mk(logic [7:0] o, logic [7:0] d, logic a, logic i, logic b, string t);
    exp_t e;
    e.oe = o; e.data = d; e.ack = a; e.irq = i; e.bsel = b; e.tag = t;
    return e;
  endfunction

  // driver: push the expectation, drive one bus cycle
  task automatic bus_cycle(input logic [1:0] jp, input logic [11:0] a, input logic r,
                           input logic w, input logic [7:0] wd, input logic [5:0] sv,
                           input logic [5:0] run, input exp_t e);
    @(posedge clk); #1;
    jumper = jp; addr = a; rd = r; wr = w; dbus_n_in = ~wd; svc_n = sv; running = run;
    exp_q.push_back(e);
  endtask

  // monitor: compare away from the active edge
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      logic [7:0] got_data;
      e = exp_q.pop_front();
      got_data = ~dbus_n_out & e.oe;
      n_checks++;
      if (oe !== e.oe || got_data !== (e.data & e.oe) || ack !== e.ack
          || irq !== e.irq || bsel !== e.bsel) begin
        n_fail++;
        $display("FAIL %s: oe=%h data=%h ack=%b irq=%b bsel=%b expected oe=%h data=%h ack=%b irq=%b bsel=%b",
                 e.tag, oe, got_data, ack, irq, bsel, e.oe, e.data & e.oe, e.ack, e.irq, e.bsel);
      end
    end
  end

  initial begin
    #(4 * 5000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R3: reset value read back
    bus_cycle(2'd0, 12'hA01, 1, 0, 8'h00, 6'h3F, 6'h00, mk(8'hFF, 8'h00, 1, 0, 1, "R3 reset value"));
    // R9: outside block
    bus_cycle(2'd0, 12'h300, 1, 0, 8'h00, 6'h3F, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R9 outside block"));
    // R1 R2: status at every jumper base
    for (int j = 0; j < 4; j++) begin
      logic [5:0] pat;
      pat = 6'h2D ^ 6'(j * 5);
      bus_cycle(2'(j), 12'hA00 + 12'(j * 'h40), 1, 0, 8'h00, 6'h3F, pat,
                mk(8'hFF, {2'b00, pat}, 1, 0, 1, "R1 R2 status at jumper base"));
    end
    // R1: jumper 2 does not decode the 0xA00 block
    bus_cycle(2'd2, 12'hA00, 1, 0, 8'h00, 6'h3F, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R1 other block"));
    // R8 R3: write all ones into config
    bus_cycle(2'd0, 12'hA01, 0, 1, 8'hFF, 6'h3F, 6'h00, mk(8'h00, 8'h00, 1, 0, 1, "R8 write ack"));
    bus_cycle(2'd0, 12'hA01, 1, 0, 8'h00, 6'h3F, 6'h00, mk(8'hFF, 8'h38, 1, 0, 1, "R3 masked readback"));
    // R4: request with enable set
    bus_cycle(2'd0, 12'h000, 0, 0, 8'h00, 6'h3B, 6'h00, mk(8'h00, 8'h00, 0, 1, 0, "R4 request raised"));
    // R5 R6: own acknowledge at lane 3
    bus_cycle(2'd0, 12'h043, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'h08, 8'hFF, 1, 0, 0, "R5 R6 ack lane 3"));
    // R5 R9: foreign acknowledge
    bus_cycle(2'd0, 12'h041, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R5 R9 foreign ack"));
    // select lane 1
    bus_cycle(2'd0, 12'hA01, 0, 1, 8'h28, 6'h3B, 6'h00, mk(8'h00, 8'h00, 1, 1, 1, "R8 write select 1"));
    bus_cycle(2'd0, 12'h041, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'h02, 8'hFF, 1, 0, 0, "R6 ack lane 1"));
    bus_cycle(2'd0, 12'h041, 1, 0, 8'h00, 6'h3F, 6'h00, mk(8'h02, 8'h00, 1, 0, 0, "R6 ack no request"));
    // R10: write other offset
    bus_cycle(2'd0, 12'hA02, 0, 1, 8'h00, 6'h3B, 6'h00, mk(8'h00, 8'h00, 1, 1, 1, "R8 write other offset"));
    bus_cycle(2'd0, 12'hA01, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'hFF, 8'h28, 1, 1, 1, "R10 config unchanged"));
    // R7: other offset reads zero
    bus_cycle(2'd0, 12'hA05, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'hFF, 8'h00, 1, 1, 1, "R7 other offset"));
    // disable, select 3
    bus_cycle(2'd0, 12'hA01, 0, 1, 8'h18, 6'h3B, 6'h00, mk(8'h00, 8'h00, 1, 1, 1, "R8 write disable"));
    bus_cycle(2'd0, 12'h000, 0, 0, 8'h00, 6'h3B, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R4 disabled quiet"));
    bus_cycle(2'd0, 12'h043, 1, 0, 8'h00, 6'h3B, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R9 ack while disabled"));
    // R2: upper lanes read zero
    bus_cycle(2'd3, 12'hAC0, 1, 0, 8'h00, 6'h3F, 6'h3F, mk(8'hFF, 8'h3F, 1, 0, 1, "R2 upper lanes zero"));
    bus_cycle(2'd3, 12'h000, 0, 0, 8'h00, 6'h3F, 6'h00, mk(8'h00, 8'h00, 0, 0, 0, "R9 idle"));

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule